// File: doc/BRIEF.md
# Gated Pulse Frequency Counter

This block measures how often an external pulse train toggles by counting its rising edges inside a fixed time window, the gate. The gate comes from a time base divided down from the system clock: a prescaler produces one tick every `TICK_DIV` clock cycles, and a phase counter built on those ticks holds the gate high for a programmable number of ticks out of a programmable period. With a 50 MHz clock and `TICK_DIV` = 10000 the tick rate is 5 kHz, so a high time of 5000 ticks in a period of 10000 ticks gives a one-second window every two seconds. A 100 ms window (500 ticks) works the same way; the reading is then ten times smaller than the rate in hertz.

The pulse input is asynchronous. It is brought into the clock domain by two flops and turned into single-cycle rising-edge strobes, so the input must stay below half the clock rate. A down-counter is set to all ones while the gate is low and steps down once per strobe while the gate is high. When the gate falls, counting has already stopped. The capture stage then stores full scale minus the residue, which equals the number of edges seen, and raises a valid flag. The counter refills during the low part of the gate, so no window misses its first edge. Shortening the period while keeping the high time the same cuts the idle time and the latency.

If the count reaches zero during a window, the counter holds at zero and a sticky overflow bit is set. That bit is captured together with the result.

Top module: `pulse_rate_meter`

## Requirements
- R1: While reset is asserted and after it is released, `result` is 0, `result_valid` is 0 and `result_ovf` is 0 until the first gate falling edge.
- R2: `gate` is high for the first `cfg_gate_high` ticks of each `cfg_gate_period`-tick cycle, where one tick is `TICK_DIV` clock cycles. The cycle starts high right after reset.
- R3: Each rising edge of `pulse_in`, after the two-flop synchronizer, is counted exactly once if it is detected while `gate` is high. Edges detected while `gate` is low are ignored.
- R4: In the clock cycle after `gate` falls, `result` holds the number of edges counted in that window (full scale minus residue) and `result_valid` is 1.
- R5: The counter is refilled to all ones while `gate` is low, so each window's result depends only on the edges inside that window.
- R6: If a window holds more than 2^`CNT_W`-1 edges, `result` reads all ones and `result_ovf` is 1. A later window without overflow reports `result_ovf` = 0.
- R7: A high `rd_ack` clears `result_valid` one cycle later. A capture in the same cycle takes priority and leaves the flag set.
- R8: The spacing between successive gate falling edges is `cfg_gate_period` × `TICK_DIV` clock cycles. Shortening the period with the same high time shortens this spacing.
- R9: `result` and `result_ovf` keep their values between gate falling edges, including across `rd_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pulse_in | input | 1 | Asynchronous pulse train to be measured |
| cfg_gate_period | input | CFG_W | Gate cycle length in ticks |
| cfg_gate_high | input | CFG_W | Gate high time in ticks (at most the period) |
| rd_ack | input | 1 | Clears the valid flag |
| gate | output | 1 | Current measurement window |
| result | output | CNT_W | Edge count of the last completed window |
| result_valid | output | 1 | A new result is waiting |
| result_ovf | output | 1 | The last window overflowed the counter |

## Verification
The bench builds the block with an 8-bit counter, a tick every 4 clocks and 8-bit gate settings. Windows are then a few dozen cycles long, and a window of 800 cycles with the input toggling every clock pushes more than 255 edges into the counter, so the saturation and sticky overflow path can be reached. The short tick also lets the bench change the gate period and time falling-edge spacing in a few hundred cycles. It covers windows at two input rates, input activity confined to the gate-low interval, and acknowledge handling between captures.

// File: rtl/prm_pkg.sv
package prm_pkg;

  // Bits needed to hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned width_for(input int unsigned n);
    int unsigned w;
    w = 1;
    for (int i = 1; i < 32; i++) begin
      if ((64'd1 << w) < 64'(n)) w = w + 1;
    end
    return w;
  endfunction

endpackage

// File: rtl/prm_tick_gate.sv
module prm_tick_gate #(
  parameter int unsigned TICK_DIV = 10000,
  parameter int unsigned CFG_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_period,
  input  logic [CFG_W-1:0] cfg_high,
  output logic             gate
);
  localparam int unsigned PRE_W = prm_pkg::width_for(TICK_DIV);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_n;
  logic [CFG_W-1:0] ph_q, ph_n;
  logic [CFG_W:0]   ph_inc;
  logic             tick;

  assign tick = (pre_q == PRE_LAST);

  always_comb begin
    pre_n  = tick ? '0 : pre_q + PRE_W'(1);
    ph_inc = {1'b0, ph_q} + (CFG_W+1)'(1);
    ph_n   = ph_q;
    if (tick) begin
      ph_n = (ph_inc >= {1'b0, cfg_period}) ? '0 : ph_inc[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ph_q  <= '0;
    end else begin
      pre_q <= pre_n;
      ph_q  <= ph_n;
    end
  end

  assign gate = (ph_q < cfg_high);

  // R2: the window phase only moves on a tick
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ph_q));
  // R2: prescaler stays inside its range
  p_pre_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_LAST);

endmodule

// File: rtl/prm_edge_sync.sv
module prm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic pulse_edge
);
  logic [2:0] sh_q, sh_n;

  always_comb sh_n = {sh_q[1:0], pulse_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign pulse_edge = sh_q[1] & ~sh_q[2];

  // R3: one strobe per rising edge, never two in a row
  p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_edge |=> !pulse_edge);

endmodule

// File: rtl/prm_down_cnt.sv
module prm_down_cnt #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_n;
  logic             ovf_n;

  always_comb begin
    cnt_n = cnt_q;
    ovf_n = ovf_q;
    if (!gate) begin
      cnt_n = FULL;
      ovf_n = 1'b0;
    end else if (step) begin
      if (cnt_q == '0) ovf_n = 1'b1;
      else             cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= FULL;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  // R5: refilled whenever the gate is low
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (cnt_q == FULL) && !ovf_q);
  // R3: one step per strobe while open
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate && step && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R3: no strobe, no change while open
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate && !step |=> $stable(cnt_q));
  // R6: overflow implies the counter is pinned at zero
  p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> cnt_q == '0);

endmodule

// File: rtl/prm_capture.sv
module prm_capture #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             ovf_q,
  input  logic             rd_ack,
  output logic [CNT_W-1:0] result,
  output logic             result_valid,
  output logic             result_ovf
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic             gate_d_q;
  logic             fall;
  logic [CNT_W-1:0] res_q, res_n;
  logic             val_q, val_n;
  logic             rov_q, rov_n;

  assign fall = gate_d_q & ~gate;

  always_comb begin
    res_n = res_q;
    rov_n = rov_q;
    val_n = val_q;
    if (fall) begin
      res_n = FULL - cnt_q;
      rov_n = ovf_q;
      val_n = 1'b1;
    end else if (rd_ack) begin
      val_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d_q <= 1'b0;
      res_q    <= '0;
      val_q    <= 1'b0;
      rov_q    <= 1'b0;
    end else begin
      gate_d_q <= gate;
      res_q    <= res_n;
      val_q    <= val_n;
      rov_q    <= rov_n;
    end
  end

  assign result       = res_q;
  assign result_valid = val_q;
  assign result_ovf   = rov_q;

  // R4: a falling gate always leaves a valid result
  p_valid_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> result_valid);
  // R9: result held between captures
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(result) && $stable(result_ovf));
  // R7: acknowledge without capture clears the flag
  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !fall |=> !result_valid);

endmodule

// File: rtl/pulse_rate_meter.sv
module pulse_rate_meter #(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned TICK_DIV = 10000,
  parameter int unsigned CFG_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic [CFG_W-1:0] cfg_gate_period,
  input  logic [CFG_W-1:0] cfg_gate_high,
  input  logic             rd_ack,
  output logic             gate,
  output logic [CNT_W-1:0] result,
  output logic             result_valid,
  output logic             result_ovf
);
  logic rs1_q, rs2_q;
  logic rst_i_n;
  logic pulse_edge;
  logic [CNT_W-1:0] cnt_q;
  logic ovf_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  prm_tick_gate #(.TICK_DIV(TICK_DIV), .CFG_W(CFG_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .cfg_period (cfg_gate_period),
    .cfg_high   (cfg_gate_high),
    .gate       (gate)
  );

  prm_edge_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .pulse_in   (pulse_in),
    .pulse_edge (pulse_edge)
  );

  prm_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .gate  (gate),
    .step  (pulse_edge),
    .cnt_q (cnt_q),
    .ovf_q (ovf_q)
  );

  prm_capture #(.CNT_W(CNT_W)) u_cap (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .gate         (gate),
    .cnt_q        (cnt_q),
    .ovf_q        (ovf_q),
    .rd_ack       (rd_ack),
    .result       (result),
    .result_valid (result_valid),
    .result_ovf   (result_ovf)
  );

  // R1: nothing valid while the internal reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_i_n |=> !result_valid || rst_i_n);

endmodule

// File: tb/tb_pulse_rate_meter.sv
module tb_pulse_rate_meter;
  localparam int CNT_W = 8;
  localparam int DIV   = 4;
  localparam int CFG_W = 8;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b0;
  logic [CFG_W-1:0] cfg_period = 8'd20;
  logic [CFG_W-1:0] cfg_high = 8'd10;
  logic rd_ack = 1'b0;
  logic gate;
  logic [CNT_W-1:0] result;
  logic result_valid, result_ovf;

  int checks = 0, failures = 0;
  bit done = 1'b0, cmp_en = 1'b0;
  int pulse_mode = 0, pulse_half = 1, pcnt = 0;
  longint cyc = 0;

  // reference model state
  bit m_r1 = 0, m_r2 = 0, h1 = 0, h2 = 0, h3 = 0, m_gd = 0;
  int m_pre = 0, m_ph = 0, m_cnt = 0;
  bit m_ovf = 0, e_val = 0, e_ovf = 0;
  int e_res = 0;

  always #10 clk = ~clk;

  pulse_rate_meter #(.CNT_W(CNT_W), .TICK_DIV(DIV), .CFG_W(CFG_W)) dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
    .cfg_gate_period(cfg_period), .cfg_gate_high(cfg_high), .rd_ack(rd_ack),
    .gate(gate), .result(result), .result_valid(result_valid), .result_ovf(result_ovf));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) cyc++;

  // behavioural reference: edges counted as an integer tally, saturating
  always @(posedge clk) begin : mdl
    bit in_rst, g_now, ed, fall, tk;
    if (!rst_n) begin
      in_rst = 1; m_r1 = 0; m_r2 = 0;
    end else begin
      in_rst = !m_r2; m_r2 = m_r1; m_r1 = 1;
    end
    if (in_rst) begin
      m_pre = 0; m_ph = 0; h1 = 0; h2 = 0; h3 = 0; m_gd = 0;
      m_cnt = 0; m_ovf = 0; e_res = 0; e_val = 0; e_ovf = 0;
    end else begin
      tk    = (m_pre == DIV - 1);
      g_now = (m_ph < int'(cfg_high));
      ed    = h2 && !h3;
      fall  = m_gd && !g_now;
      if (fall) begin
        e_res = m_cnt; e_ovf = m_ovf; e_val = 1;
      end else if (rd_ack) e_val = 0;
      if (!g_now) begin
        m_cnt = 0; m_ovf = 0;
      end else if (ed) begin
        if (m_cnt == MAXC) m_ovf = 1;
        else m_cnt++;
      end
      m_gd = g_now;
      h3 = h2; h2 = h1; h1 = pulse_in;
      if (tk) m_ph = (m_ph + 1 >= int'(cfg_period)) ? 0 : m_ph + 1;
      m_pre = tk ? 0 : m_pre + 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2 gate", gate, (m_ph < int'(cfg_high)));
      chk("R4 result", result, e_res);
      chk("R7 result_valid", result_valid, e_val);
      chk("R6 result_ovf", result_ovf, e_ovf);
    end
  end

  // stimulus pulse source
  always @(negedge clk) begin
    if (pulse_mode == 1) begin
      if (pcnt >= pulse_half - 1) begin
        pulse_in <= ~pulse_in; pcnt <= 0;
      end else pcnt <= pcnt + 1;
    end else if (pulse_mode == 2) begin
      if (!gate) pulse_in <= ~pulse_in;
    end else pulse_in <= 1'b0;
  end

  task automatic wait_capture();
    bit prev;
    prev = gate;
    forever begin
      @(negedge clk);
      if (prev && !gate) break;
      prev = gate;
    end
    @(negedge clk);
  endtask

  task automatic fall_gap(output longint gap);
    longint t0;
    wait_capture();
    t0 = cyc;
    wait_capture();
    gap = cyc - t0;
  endtask

  initial begin
    longint gap;
    repeat (5) @(negedge clk);
    chk("R1 valid in reset", result_valid, 0);
    chk("R1 result in reset", result, 0);
    chk("R1 ovf in reset", result_ovf, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", result_valid, 0);
    chk("R2 gate opens after reset", gate, 1);

    // R4: 4-cycle pulse period, 40-cycle window -> about 10 edges
    pulse_mode = 1; pulse_half = 2;
    wait_capture();
    wait_capture();
    chk("R4 result vs model", result, e_res);
    chk("R4 result near 10", (result >= 9 && result <= 11), 1);
    chk("R4 valid set", result_valid, 1);

    // R5: faster input, each window stands alone -> about 20
    pulse_half = 1;
    wait_capture();
    wait_capture();
    chk("R5 result near 20", (result >= 19 && result <= 21), 1);
    chk("R5 result vs model", result, e_res);

    // R7 / R9: acknowledge clears the flag, result unchanged
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    chk("R7 valid cleared by ack", result_valid, 0);
    chk("R9 result held over ack", result, e_res);
    repeat (5) @(negedge clk);
    chk("R9 result still held", result, e_res);

    // R3: input moves only while gate is low
    pulse_mode = 2;
    wait_capture();
    wait_capture();
    chk("R3 gate-low edges ignored", (result <= 1), 1);
    chk("R3 result vs model", result, e_res);

    // R8: falling-edge spacing follows the period
    pulse_mode = 1; pulse_half = 2;
    fall_gap(gap);
    chk("R8 spacing period 20", gap, 20 * DIV);
    cfg_period = 8'd12;
    wait_capture();
    fall_gap(gap);
    chk("R8 spacing period 12", gap, 12 * DIV);
    chk("R8 count unchanged with short period", (result >= 9 && result <= 11), 1);

    // R6: 800-cycle window, toggle every clock -> 400 edges
    cfg_period = 8'd255; cfg_high = 8'd200; pulse_half = 1;
    wait_capture();
    wait_capture();
    chk("R6 saturated result", result, MAXC);
    chk("R6 overflow flag", result_ovf, 1);

    // R6: overflow does not stick into the next clean window
    cfg_period = 8'd20; cfg_high = 8'd10; pulse_half = 2;
    wait_capture();
    wait_capture();
    chk("R6 overflow cleared", result_ovf, 0);

    // R7: capture wins over a simultaneous acknowledge
    begin : ack_race
      bit prev;
      prev = gate;
      forever begin
        @(negedge clk);
        if (prev && !gate) break;
        prev = gate;
      end
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
      chk("R7 capture beats ack", result_valid, 1);
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule